// File: doc/BRIEF.md
# Next Program Counter Address Generator

This combinational block computes the address of the next instruction for a 32-bit load/store processor whose instructions are all one word long. Each cycle it receives the current program counter, the low part of the fetched instruction word (the 16-bit immediate and the 26-bit jump index), two register operands, and decoded control selects. From these it forms four candidates: the fall-through address, a PC-relative branch target, a region-limited jump target, and a register-held absolute address. It then picks one of them.

A conditional branch is taken on operand equality or on operand inequality. The control selects say which test applies. When a link is requested, the block also produces the return address, a write strobe and the fixed destination register index. A later register jump through that register then resumes at the instruction after the call. Instruction memory, the register file, exceptions and delay slots belong to other blocks.

Top module: `npc_gen`

## Requirements
- R1: With no branch, jump or register-jump select active, `next_pc_o` equals `pc_i + 4`.
- R2: A taken branch gives `next_pc_o = pc_i + 4 + (sign-extended idx_i[15:0] << 2)`. For example, pc 0x00400010 with immediate 0x0005 gives 0x00400028.
- R3: The immediate is sign-extended before the shift, so a negative immediate moves the PC backward. Immediate 0xFFFF gives `pc_i`, and 0x8000 gives `pc_i + 4 - 0x20000`.
- R4: With `br_en_i=1`, the branch is taken when `br_ne_i=0` and `rs_val_i == rt_val_i`, or when `br_ne_i=1` and the operands differ. Otherwise `next_pc_o = pc_i + 4`.
- R5: With `jmp_en_i=1`, `next_pc_o = {pc_i[31:28], idx_i[25:0], 2'b00}`.
- R6: A region jump never changes the upper four bits of the PC, including when `pc_i + 4` would carry into them.
- R7: With `jr_en_i=1`, `next_pc_o` equals all 32 bits of `rs_val_i`.
- R8: With `link_en_i=1` and either jump select active, `link_we_o=1`, `link_idx_o=31` and `link_addr_o = pc_i + 4`. Otherwise `link_we_o=0`.
- R9: When several selects are active together, the register jump wins, then the region jump, then a taken branch, then fall-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Current program counter |
| idx_i | input | 26 | Low 26 bits of the instruction: jump index, whose bits 15:0 are the branch immediate |
| rs_val_i | input | 32 | First register operand; also the register-jump target |
| rt_val_i | input | 32 | Second register operand for the branch compare |
| br_en_i | input | 1 | Instruction is a conditional branch |
| br_ne_i | input | 1 | Branch tests inequality (0 tests equality) |
| jmp_en_i | input | 1 | Instruction is a region jump |
| jr_en_i | input | 1 | Instruction is a register jump |
| link_en_i | input | 1 | Jump also writes the return address |
| next_pc_o | output | 32 | Selected next program counter |
| link_addr_o | output | 32 | Return address |
| link_we_o | output | 1 | Return-address write strobe |
| link_idx_o | output | 5 | Destination register index for the return address |

## Verification
Branches are tried with equal and unequal operands under both compare senses. This separates the taken path from the not-taken path. Positive, zero, all-ones and most-negative immediates show whether sign extension happens before the shift. Region jumps from a PC just below a 256 MB boundary show whether the upper bits come from the current PC or from the incremented one. Overlapping selects and linked versus unlinked jumps expose the priority order and the strobe gating.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN    = 32;
  localparam int IMM_W   = 16;
  localparam int JIDX_W  = 26;
  localparam int STEP    = 4;
  localparam int RIDX_W  = 5;
  localparam int LINK_RG = 31;

  typedef logic [XLEN-1:0] addr_t;

  typedef enum logic [1:0] {
    PICK_SEQ = 2'd0,
    PICK_BR  = 2'd1,
    PICK_JMP = 2'd2,
    PICK_REG = 2'd3
  } pick_e;
endpackage

// File: rtl/npc_seq_inc.sv
module npc_seq_inc #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] inc_o
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  always_comb begin
    inc_o = pc_i + STEP_V;
  end
endmodule

// File: rtl/npc_br_target.sv
module npc_br_target #(
  parameter int AW    = 32,
  parameter int IMM_W = 16,
  parameter int STEP  = 4
) (
  input  logic [AW-1:0]    inc_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [AW-1:0]    tgt_o
);
  localparam int SH = $clog2(STEP);
  localparam int EXT = AW - IMM_W;

  logic [AW-1:0] sext;

  always_comb begin
    sext  = {{EXT{imm_i[IMM_W-1]}}, imm_i};
    tgt_o = inc_i + (sext << SH);
  end
endmodule

// File: rtl/npc_jmp_target.sv
module npc_jmp_target #(
  parameter int AW     = 32,
  parameter int JIDX_W = 26,
  parameter int STEP   = 4
) (
  input  logic [AW-JIDX_W-$clog2(STEP)-1:0] region_i,
  input  logic [JIDX_W-1:0]                 jidx_i,
  output logic [AW-1:0]                     tgt_o
);
  localparam int SH = $clog2(STEP);

  always_comb begin
    tgt_o = {region_i, jidx_i, {SH{1'b0}}};
  end
endmodule

// File: rtl/npc_pick.sv
module npc_pick
  import npc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] rs_i,
  input  logic [AW-1:0] rt_i,
  input  logic          br_en_i,
  input  logic          br_ne_i,
  input  logic          jmp_en_i,
  input  logic          jr_en_i,
  output logic          taken_o,
  output pick_e         pick_o
);
  logic same;

  always_comb begin
    same    = (rs_i == rt_i);
    taken_o = br_en_i & (br_ne_i ? ~same : same);
    if (jr_en_i)       pick_o = PICK_REG;
    else if (jmp_en_i) pick_o = PICK_JMP;
    else if (taken_o)  pick_o = PICK_BR;
    else               pick_o = PICK_SEQ;
  end

  always_comb begin
    if (br_en_i && !jmp_en_i && !jr_en_i && (br_ne_i == same)) begin
      p_untaken_seq_r4: assert (pick_o == PICK_SEQ);
    end
  end
endmodule

// File: rtl/npc_gen.sv
module npc_gen
  import npc_pkg::*;
(
  input  logic [XLEN-1:0]   pc_i,
  input  logic [JIDX_W-1:0] idx_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  input  logic              br_en_i,
  input  logic              br_ne_i,
  input  logic              jmp_en_i,
  input  logic              jr_en_i,
  input  logic              link_en_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic [XLEN-1:0]   link_addr_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_idx_o
);
  localparam int SH    = $clog2(STEP);
  localparam int REG_W = XLEN - JIDX_W - SH;

  addr_t inc, br_tgt, jmp_tgt;
  pick_e pick;
  logic  taken;

  npc_seq_inc #(.AW(XLEN), .STEP(STEP)) u_inc (
    .pc_i (pc_i),
    .inc_o(inc)
  );

  npc_br_target #(.AW(XLEN), .IMM_W(IMM_W), .STEP(STEP)) u_br (
    .inc_i(inc),
    .imm_i(idx_i[IMM_W-1:0]),
    .tgt_o(br_tgt)
  );

  npc_jmp_target #(.AW(XLEN), .JIDX_W(JIDX_W), .STEP(STEP)) u_jmp (
    .region_i(pc_i[XLEN-1 -: REG_W]),
    .jidx_i  (idx_i),
    .tgt_o   (jmp_tgt)
  );

  npc_pick #(.AW(XLEN)) u_pick (
    .rs_i    (rs_val_i),
    .rt_i    (rt_val_i),
    .br_en_i (br_en_i),
    .br_ne_i (br_ne_i),
    .jmp_en_i(jmp_en_i),
    .jr_en_i (jr_en_i),
    .taken_o (taken),
    .pick_o  (pick)
  );

  always_comb begin
    unique case (pick)
      PICK_REG: next_pc_o = rs_val_i;
      PICK_JMP: next_pc_o = jmp_tgt;
      PICK_BR:  next_pc_o = br_tgt;
      default:  next_pc_o = inc;
    endcase
    link_addr_o = inc;
    link_we_o   = link_en_i & (jmp_en_i | jr_en_i);
    link_idx_o  = RIDX_W'(LINK_RG);
  end

  always_comb begin
    if (!br_en_i && !jmp_en_i && !jr_en_i) begin
      p_fallthrough_r1: assert (next_pc_o == pc_i + XLEN'(STEP));
    end
    if (jr_en_i) begin
      p_reg_full_r7: assert (next_pc_o == rs_val_i);
    end
    if (jmp_en_i && !jr_en_i) begin
      p_region_kept_r6: assert (next_pc_o[XLEN-1 -: REG_W] == pc_i[XLEN-1 -: REG_W]);
    end
    if (link_we_o) begin
      p_link_ret_r8: assert (link_addr_o == pc_i + XLEN'(STEP));
    end
    if (taken && !jmp_en_i && !jr_en_i) begin
      p_branch_off_r2: assert ((next_pc_o - link_addr_o) ==
                               ({{(XLEN-IMM_W){idx_i[IMM_W-1]}}, idx_i[IMM_W-1:0]} << SH));
    end
  end
endmodule

// File: tb/sim_npc_gen.sv
module sim_npc_gen;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] pc, rs, rt, npc, la;
  logic [25:0] idx;
  logic br, bne, jmp, jr, lk, lwe;
  logic [4:0] lidx;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  npc_gen u0 (
    .pc_i(pc), .idx_i(idx), .rs_val_i(rs), .rt_val_i(rt),
    .br_en_i(br), .br_ne_i(bne), .jmp_en_i(jmp), .jr_en_i(jr),
    .link_en_i(lk), .next_pc_o(npc), .link_addr_o(la),
    .link_we_o(lwe), .link_idx_o(lidx)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] p, logic [25:0] ix, logic [31:0] a, logic [31:0] b,
                       logic e_br, logic e_ne, logic e_j, logic e_jr, logic e_lk);
    @(negedge clk);
    pc = p; idx = ix; rs = a; rt = b;
    br = e_br; bne = e_ne; jmp = e_j; jr = e_jr; lk = e_lk;
    #2;
  endtask

  function automatic logic [31:0] btgt(logic [31:0] p, logic [15:0] imm);
    return p + 32'd4 + 32'($signed(imm)) * 32'sd4;
  endfunction

  task automatic t_idle_r1();
    drive(32'h0000_0000, 26'h0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 idle", npc, 32'h0000_0004);
    chk("R8 idle no write", {31'd0, lwe}, 32'd0);
    drive(32'hFFFF_FFFC, 26'h3FF_FFFF, 1, 2, 0, 0, 0, 0, 1);
    chk("R1 wrap", npc, 32'h0000_0000);
    chk("R8 link without jump", {31'd0, lwe}, 32'd0);
  endtask

  task automatic t_branch_r2();
    drive(32'h0040_0010, 26'h5, 32'h7, 32'h7, 1, 0, 0, 0, 0);
    chk("R2 example", npc, 32'h0040_0028);
    drive(32'h1234_5678, 26'h7FFF, 32'h9, 32'h9, 1, 0, 0, 0, 0);
    chk("R2 max forward", npc, btgt(32'h1234_5678, 16'h7FFF));
  endtask

  task automatic t_backward_r3();
    drive(32'h0040_0100, 26'h3FF_FFFF, 5, 5, 1, 0, 0, 0, 0);
    chk("R3 minus one", npc, 32'h0040_0100);
    drive(32'h0050_0000, 26'h8000, 5, 5, 1, 0, 0, 0, 0);
    chk("R3 most negative", npc, 32'h0050_0004 - 32'h0002_0000);
  endtask

  task automatic t_sense_r4();
    drive(32'h0000_1000, 26'h10, 3, 4, 1, 0, 0, 0, 0);
    chk("R4 eq untaken", npc, 32'h0000_1004);
    drive(32'h0000_1000, 26'h10, 3, 4, 1, 1, 0, 0, 0);
    chk("R4 ne taken", npc, 32'h0000_1044);
    drive(32'h0000_1000, 26'h10, 8, 8, 1, 1, 0, 0, 0);
    chk("R4 ne untaken", npc, 32'h0000_1004);
  endtask

  task automatic t_jump_r5_r6();
    drive(32'hA000_0040, 26'h123_4567, 0, 0, 0, 0, 1, 0, 0);
    chk("R5 jump", npc, {4'hA, 26'h123_4567, 2'b00});
    drive(32'h3FFF_FFFC, 26'h000_0010, 0, 0, 0, 0, 1, 0, 0);
    chk("R6 region from pc", npc, 32'h3000_0040);
  endtask

  task automatic t_reg_r7_link_r8();
    drive(32'h0000_2000, 26'h0, 32'hDEAD_BEEC, 0, 0, 0, 0, 1, 0);
    chk("R7 reg jump", npc, 32'hDEAD_BEEC);
    drive(32'h0040_0200, 26'h10_0000, 0, 0, 0, 0, 1, 0, 1);
    chk("R8 link addr", la, 32'h0040_0204);
    chk("R8 link we", {31'd0, lwe}, 32'd1);
    chk("R8 link idx", {27'd0, lidx}, 32'd31);
    drive(32'h0040_0300, 26'h0, 32'h0040_0204, 0, 0, 0, 0, 1, 0);
    chk("R7 return", npc, 32'h0040_0204);
    chk("R8 no link", {31'd0, lwe}, 32'd0);
  endtask

  task automatic t_priority_r9();
    drive(32'h1000_0000, 26'h2, 32'h5555_0000, 32'h5555_0000, 1, 0, 1, 1, 0);
    chk("R9 reg over all", npc, 32'h5555_0000);
    drive(32'h1000_0000, 26'h2, 7, 7, 1, 0, 1, 0, 0);
    chk("R9 jump over branch", npc, 32'h1000_0008);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_idle_r1();
    t_branch_r2();
    t_backward_r3();
    t_sense_r4();
    t_jump_r5_r6();
    t_reg_r7_link_r8();
    t_priority_r9();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule